// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves a single active-low external interrupt pin for a small 8-bit processor. The asynchronous pin passes through a synchronizer, falling edges are detected on the synchronized level, and a pending-request flag is latched. The flag can run in one of two trigger styles chosen by a control bit. In edge style any acknowledge clears it. In edge-plus-level style it stays pending for as long as the pin is held low. It is released only once an acknowledge has arrived and the pin has gone high again, and these two events may come in either order.

Software reaches the block through a small register port with two locations. The first is a control and status location holding the pending flag, a write-one acknowledge, an interrupt mask and the trigger-style bit. The second is an option location holding a pull-up disable bit, which is brought out as a plain output. The processor receives a masked interrupt request, returns a one-cycle acknowledge pulse when it fetches the vector, and can read the synchronized pin level for branch-on-pin instructions.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on `pin_n` sets the pending flag. With the default two-stage synchronizer, the flag is visible on the third rising clock edge after the pin goes low.
- R2: Address 0 is the control/status location. Bit 0 is the trigger style (0 edge, 1 edge-plus-level), bit 1 is the mask, bit 2 is write-one acknowledge and always reads 0, bit 3 is the read-only pending flag, and bits 7:4 read 0. All bits reset to 0.
- R3: In edge style, an acknowledge clears the pending flag on the next clock edge even while the pin stays low. An acknowledge is either a `vec_ack` pulse or a write to address 0 with bit 2 set.
- R4: In edge-plus-level style, the pending flag holds while the synchronized pin is low, even after an acknowledge. It clears once an acknowledge has occurred and the synchronized pin is high, with either event allowed to come first.
- R5: The pending flag reads back in bit 3 of address 0 whatever the value of the mask.
- R6: `cpu_irq` is high exactly when the pending flag is set and the mask is 0.
- R7: A falling edge detected in the same cycle as an acknowledge leaves the pending flag set. A falling edge after an acknowledge latches a new request.
- R8: Address 1 holds the pull-up disable in bit 0, which drives `pullup_dis` and resets to 0. Bits 7:1 of address 1 read 0.
- R9: Reset clears the pending flag, the mask and the trigger style. A pin already low when reset ends does not raise a request; a request needs the pin to be seen high and then fall.
- R10: `pin_level` is the pin level after the synchronizer. With the default two stages it follows `pin_n` after two rising clock edges, and it reads 0 while the synchronizer is being refilled after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| bus_addr | input | ADDR_W | Register select (0 control/status, 1 option) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| vec_ack | input | 1 | One-cycle acknowledge from the vector fetch |
| cpu_irq | output | 1 | Masked interrupt request to the processor |
| pin_level | output | 1 | Synchronized pin level |
| pullup_dis | output | 1 | Pull-up disable control |

## Verification
In edge style, the pin is driven low and held low, so that a clear by acknowledge can be told apart from a clear caused by the pin level. In edge-plus-level style, the acknowledge is placed first in one pass and last in the other, and the flag is sampled one cycle before and one cycle after the synchronized pin returns high. This shows that neither event alone releases it. A falling edge is made to coincide with an acknowledge while the flag is already set, which tells edge priority apart from acknowledge priority. Reset is applied with the pin held low, which separates a clean restart from a spurious edge produced by the synchronizer refilling.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_STYLE = 0;
  localparam int unsigned BIT_MASK  = 1;
  localparam int unsigned BIT_ACK   = 2;
  localparam int unsigned BIT_PEND  = 3;
  localparam int unsigned BIT_PUDIS = 0;

  typedef struct packed {
    logic mask;
    logic level_style;
  } ctl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] shift_q, shift_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb shift_d = pin_n;
    end else begin : g_many
      always_comb shift_d = {shift_q[STAGES-2:0], pin_n};
    end
  endgenerate

  always_comb prev_d = shift_q[STAGES-1];

  // Reset to 0 so a pin held low across reset yields no falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      prev_q  <= prev_d;
    end
  end

  assign level = shift_q[STAGES-1];
  assign fall  = prev_q & ~level;

  a_r9_no_fall_twice: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic level,
  input  logic level_style,
  input  logic ack,
  output logic pend
);
  logic pend_q, pend_d;
  logic acked_q, acked_d;
  logic upd_en;

  always_comb begin
    pend_d  = pend_q;
    acked_d = acked_q;
    if (fall) begin
      pend_d  = 1'b1;
      acked_d = 1'b0;
    end else if (pend_q) begin
      if (!level_style) begin
        if (ack) pend_d = 1'b0;
        acked_d = 1'b0;
      end else if ((ack || acked_q) && level) begin
        pend_d  = 1'b0;
        acked_d = 1'b0;
      end else if (ack) begin
        acked_d = 1'b1;
      end
    end else begin
      acked_d = 1'b0;
    end
  end

  assign upd_en = fall | pend_q | acked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      acked_q <= 1'b0;
    end else if (upd_en) begin
      pend_q  <= pend_d;
      acked_q <= acked_d;
    end
  end

  assign pend = pend_q;

  a_r1_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pend_q);
  a_r3_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_style && ack && !fall) |=> !pend_q);
  a_r4_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (level_style && pend_q && !level) |=> pend_q);
  a_r4_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (level_style && pend_q && !ack && !acked_q) |=> pend_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 1,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned OPT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              pend,
  output logic [REG_W-1:0]  rdata,
  output ctl_t              ctl,
  output logic              pudis,
  output logic              sw_ack
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] OPT_SEL = ADDR_W'(OPT_ADDR);

  logic sel_ctl, sel_opt;
  logic ctl_en, opt_en;
  ctl_t ctl_q, ctl_d;
  logic pud_q, pud_d;
  logic unused_wbits;

  assign sel_ctl = (addr == CTL_SEL);
  assign sel_opt = (addr == OPT_SEL);
  assign ctl_en  = wr & sel_ctl;
  assign opt_en  = wr & sel_opt;

  always_comb begin
    ctl_d.mask        = wdata[BIT_MASK];
    ctl_d.level_style = wdata[BIT_STYLE];
    pud_d             = wdata[BIT_PUDIS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pud_q <= 1'b0;
    end else if (opt_en) begin
      pud_q <= pud_d;
    end
  end

  assign sw_ack = ctl_en & wdata[BIT_ACK];

  always_comb begin
    rdata = '0;
    if (sel_ctl) begin
      rdata[BIT_PEND]  = pend;
      rdata[BIT_MASK]  = ctl_q.mask;
      rdata[BIT_STYLE] = ctl_q.level_style;
    end else if (sel_opt) begin
      rdata[BIT_PUDIS] = pud_q;
    end
  end

  assign ctl          = ctl_q;
  assign pudis        = pud_q;
  assign unused_wbits = &{1'b0, wdata[REG_W-1:BIT_PEND]};

  a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctl |-> (rdata[BIT_ACK] == 1'b0) && (rdata[REG_W-1:BIT_PEND+1] == '0));
  a_r8_opt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_opt |-> (rdata[REG_W-1:BIT_PUDIS+1] == '0));
  a_r8_opt_write: assert property (@(posedge clk) disable iff (!rst_n)
    opt_en |=> (pudis == $past(wdata[BIT_PUDIS])));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned CTL_ADDR    = 0,
  parameter int unsigned OPT_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              vec_ack,
  output logic              cpu_irq,
  output logic              pin_level,
  output logic              pullup_dis
);
  logic level, fall, pend, sw_ack, any_ack;
  ctl_t ctl;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .level(level), .fall(fall)
  );

  ext_irq_regs #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .OPT_ADDR(OPT_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .pend(pend), .rdata(bus_rdata), .ctl(ctl), .pudis(pullup_dis), .sw_ack(sw_ack)
  );

  assign any_ack = vec_ack | sw_ack;

  ext_irq_pend pend_i (
    .clk(clk), .rst_n(rst_n), .fall(fall), .level(level),
    .level_style(ctl.level_style), .ack(any_ack), .pend(pend)
  );

  assign cpu_irq   = pend & ~ctl.mask;
  assign pin_level = level;

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mask |-> !cpu_irq);
  a_r5_flag_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTL_ADDR) && cpu_irq) |-> bus_rdata[BIT_PEND]);
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
  typedef enum int { K_IRQ, K_LVL, K_PUD, K_RD } kind_t;
  typedef struct { kind_t kind; logic [7:0] exp; string tag; } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic [0:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       vec_ack = 1'b0;
  logic [7:0] bus_rdata;
  logic       cpu_irq, pin_level, pullup_dis;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_ack(vec_ack), .cpu_irq(cpu_irq), .pin_level(pin_level),
    .pullup_dis(pullup_dis)
  );

  // Monitor: pops expectations and compares them away from the rising edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_IRQ:   act = {7'd0, cpu_irq};
        K_LVL:   act = {7'd0, pin_level};
        K_PUD:   act = {7'd0, pullup_dis};
        default: act = bus_rdata;
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input kind_t k, input logic [7:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic expect_rd(input logic a, input logic [7:0] e, input string t);
    bus_addr = a;
    push(K_RD, e, t);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse_ack();
    vec_ack = 1'b1;
    tick(1);
    vec_ack = 1'b0;
  endtask

  task automatic finish_run();
    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(3);
    // R2, R8, R10: reset state
    expect_rd(1'b0, 8'h00, "R2 reset control");
    push(K_IRQ, 8'h00, "R6 reset irq");
    push(K_LVL, 8'h01, "R10 level high");
    tick(1);
    expect_rd(1'b1, 8'h00, "R8 reset option");
    push(K_PUD, 8'h00, "R8 reset pullup");
    tick(1);

    // R1, R10: edge style, pin falls
    pin_n = 1'b0;
    tick(2);
    push(K_LVL, 8'h00, "R10 level low after two edges");
    expect_rd(1'b0, 8'h00, "R1 not yet pending");
    tick(1);
    expect_rd(1'b0, 8'h08, "R1 pending on third edge");
    push(K_IRQ, 8'h01, "R6 irq unmasked");
    tick(1);

    // R5, R6: mask
    wr(1'b0, 8'h02);
    expect_rd(1'b0, 8'h0A, "R5 flag visible while masked");
    push(K_IRQ, 8'h00, "R6 masked irq low");
    tick(1);
    wr(1'b0, 8'h00);
    push(K_IRQ, 8'h01, "R6 unmasked irq high");
    tick(1);

    // R3: vector acknowledge while pin still low
    pulse_ack();
    expect_rd(1'b0, 8'h00, "R3 vec ack clears edge style");
    push(K_IRQ, 8'h00, "R3 irq dropped");
    tick(1);

    // R3, R2: software acknowledge, ack reads 0
    pin_n = 1'b1; tick(3);
    pin_n = 1'b0; tick(3);
    expect_rd(1'b0, 8'h08, "R1 second edge");
    tick(1);
    wr(1'b0, 8'h04);
    expect_rd(1'b0, 8'h00, "R3 sw ack clears, R2 ack reads 0");
    tick(1);

    // R4: level style, ack first then pin high
    pin_n = 1'b1; tick(3);
    wr(1'b0, 8'h01);
    pin_n = 1'b0; tick(3);
    expect_rd(1'b0, 8'h09, "R4 pending in level style");
    tick(1);
    pulse_ack();
    expect_rd(1'b0, 8'h09, "R4 ack alone while low holds");
    push(K_IRQ, 8'h01, "R4 irq still high");
    tick(1);
    pin_n = 1'b1; tick(2);
    expect_rd(1'b0, 8'h09, "R4 holds until synced high");
    tick(1);
    expect_rd(1'b0, 8'h01, "R4 clears after ack then high");
    tick(1);

    // R4: level style, pin high first then ack
    pin_n = 1'b0; tick(3);
    pin_n = 1'b1; tick(3);
    expect_rd(1'b0, 8'h09, "R4 high alone does not clear");
    tick(1);
    wr(1'b0, 8'h05);
    expect_rd(1'b0, 8'h01, "R4 clears after high then ack");
    tick(1);

    // R7: edge and ack in the same cycle, flag already set
    wr(1'b0, 8'h00);
    pin_n = 1'b0; tick(3);
    pin_n = 1'b1; tick(3);
    expect_rd(1'b0, 8'h08, "R7 setup pending");
    tick(1);
    pin_n = 1'b0; tick(2);
    pulse_ack();
    expect_rd(1'b0, 8'h08, "R7 edge wins over ack");
    tick(1);
    pulse_ack();
    expect_rd(1'b0, 8'h00, "R7 later ack clears");
    tick(1);
    pin_n = 1'b1; tick(3);
    pin_n = 1'b0; tick(3);
    expect_rd(1'b0, 8'h08, "R7 edge after ack relatches");
    tick(1);

    // R8: option register
    wr(1'b1, 8'hFF);
    expect_rd(1'b1, 8'h01, "R8 only bit0 stored");
    push(K_PUD, 8'h01, "R8 pullup disable out");
    tick(1);

    // R9: reset with pin held low in level style
    wr(1'b0, 8'h03);
    pin_n = 1'b1; tick(3);
    pin_n = 1'b0; tick(3);
    expect_rd(1'b0, 8'h0B, "R9 setup pending masked");
    push(K_IRQ, 8'h00, "R6 masked in level style");
    tick(1);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(4);
    expect_rd(1'b0, 8'h00, "R9 reset clears with pin low");
    push(K_IRQ, 8'h00, "R9 irq low after reset");
    push(K_PUD, 8'h00, "R8 pullup reset");
    push(K_LVL, 8'h00, "R10 level low");
    tick(1);
    pin_n = 1'b1; tick(3);
    pin_n = 1'b0; tick(3);
    expect_rd(1'b0, 8'h08, "R9 edge style after reset");
    push(K_IRQ, 8'h01, "R9 irq after fresh edge");
    tick(1);
    pulse_ack();
    expect_rd(1'b0, 8'h00, "R9 mode reset to edge style");
    tick(1);

    finish_run();
  end
endmodule